// File: doc/BRIEF.md
# Startup Overcurrent Trip Level Calibrator

This block sets the overcurrent trip reference of a switching regulator once, at power-up, before soft-start may begin. When a start request arrives it turns on an external bias current source, which develops the set voltage across an external resistor. It then ramps a 6-bit DAC code upward from zero, one step per prescaled tick. An external comparator reports when the DAC output has reached the set voltage.

The first code at which the comparator is high, and is still high on the next tick, is frozen. That code stays on the DAC lines and drives the run-time current comparator. An effective trip code is derived from it: the lowest codes are folded to zero. The block then raises a done flag that releases soft-start. If the ramp reaches the top code without a crossing, calibration still completes but the limit-enable output stays low. The analog DAC, comparator and current source sit outside the block.

Top module: `trip_ramp_cal`

## Requirements
- R1: While reset is asserted and after it is released with no start, bias_en, done and limit_en are 0, and dac_code and trip_code are 0.
- R2: bias_en is 1 from the clock after a start request in the idle state until the cycle in which done rises, and 0 at all other times.
- R3: During the ramp, dac_code only changes by +1, and in a run with no comparator activity consecutive increments are exactly PRESCALE clock cycles apart.
- R4: The comparator input (1 = DAC level at or above the set voltage) passes through a two-flop synchronizer and is sampled on step ticks. A code is accepted only when the comparator is seen high on two consecutive ticks, with the code held between them. For a comparator that goes high at code N (0 to 63), dac_code ends at N and limit_en is 1.
- R5: A comparator high that lasts for only one step tick is ignored: the ramp resumes from the held code and the final code is that of the first sustained crossing.
- R6: The effective trip_code equals the accepted code when that code is above ZERO_MAX (default 10), and is 0 when the code is 0 to ZERO_MAX; limit_en is still 1 in that case.
- R7: If the comparator is still low when it is sampled at code 63, done rises with limit_en = 0, trip_code = 0 and dac_code = 63.
- R8: Once done is 1 it stays 1, and dac_code, trip_code and limit_en stay constant until the next reset; further start requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Calibration start request, sampled in idle |
| cmp_raw | input | 1 | Asynchronous comparator: 1 when DAC level is at or above the set voltage |
| bias_en | output | 1 | Enables the external bias current into the set resistor |
| dac_code | output | CODE_W | Ramp code to the DAC; holds the accepted code after completion |
| trip_code | output | CODE_W | Effective trip code, low codes folded to zero |
| done | output | 1 | Calibration complete; releases soft-start |
| limit_en | output | 1 | Current limiting enabled (a crossing was found) |

## Verification
The bench sweeps the comparator threshold over every code from 0 to 63, plus the case that never crosses. This catches an off-by-one freeze, which would leave the code one step past the crossing, and a fold boundary set at the wrong code, which would either zero code 11 or keep code 10. Single-tick comparator glitches are placed below the true threshold; a design without two-tick confirmation would freeze at the glitch code. The no-crossing run and the start pulse sent after completion expose a design that enables limiting with a top code, or that restarts and turns the bias back on.

// File: rtl/trip_ramp_cal.sv
module trip_ramp_cal #(
  parameter int CODE_W       = 6,
  parameter int PRESCALE     = 500000,
  parameter int SETTLE_TICKS = 16,
  parameter int ZERO_MAX     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmp_raw,
  output logic              bias_en,
  output logic [CODE_W-1:0] dac_code,
  output logic [CODE_W-1:0] trip_code,
  output logic              done,
  output logic              limit_en
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam int SW = $clog2(SETTLE_TICKS + 1);
  localparam logic [CODE_W-1:0] TOP_CODE  = '1;
  localparam logic [CODE_W-1:0] ZERO_CODE = CODE_W'(ZERO_MAX);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_RAMP, S_DONE} st_t;
  st_t st;

  logic [PW-1:0] pre;
  logic [SW-1:0] stl;
  logic          cmp_m, cmp_s, pend;
  logic          busy, tick;

  assign busy    = (st == S_SETTLE) || (st == S_RAMP);
  assign tick    = busy && (pre == PW'(PRESCALE - 1));
  assign bias_en = busy;
  assign done    = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_m <= 1'b0;
      cmp_s <= 1'b0;
    end else begin
      cmp_m <= cmp_raw;
      cmp_s <= cmp_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || tick) pre <= '0;
    else                         pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      stl       <= '0;
      pend      <= 1'b0;
      dac_code  <= '0;
      trip_code <= '0;
      limit_en  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_SETTLE;
          stl      <= '0;
          pend     <= 1'b0;
          dac_code <= '0;
        end
        S_SETTLE: if (tick) begin
          if (stl == SW'(SETTLE_TICKS - 1)) st <= S_RAMP;
          else                              stl <= stl + 1'b1;
        end
        S_RAMP: if (tick) begin
          if (cmp_s) begin
            if (pend) begin
              st        <= S_DONE;
              limit_en  <= 1'b1;
              trip_code <= (dac_code <= ZERO_CODE) ? '0 : dac_code;
            end else begin
              pend <= 1'b1;
            end
          end else begin
            pend <= 1'b0;
            if (dac_code == TOP_CODE) begin
              st        <= S_DONE;
              limit_en  <= 1'b0;
              trip_code <= '0;
            end else begin
              dac_code <= dac_code + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_BIAS_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bias_en)); // R2
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(dac_code)) |-> (dac_code == $past(dac_code) + 1'b1)); // R3
  AST_CROSS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && limit_en) |-> $past(cmp_s)); // R4
  AST_ZERO_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_en && dac_code <= ZERO_CODE) |-> (trip_code == '0)); // R6
  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !limit_en) |-> (dac_code == TOP_CODE && trip_code == '0)); // R7
  AST_LIMIT_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    limit_en |-> done); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R8
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(dac_code) && $stable(trip_code) && $stable(limit_en))); // R8
endmodule

// File: tb/trip_ramp_cal_test.sv
module trip_ramp_cal_test;
  localparam int PS = 4;
  localparam int ST = 2;
  localparam int ZM = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic glitch = 1'b0;
  int   thr = 64;
  logic cmp_raw;
  logic bias_en, done, limit_en;
  logic [5:0] dac_code, trip_code;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  assign cmp_raw = (int'(dac_code) >= thr) ^ glitch;

  trip_ramp_cal #(.CODE_W(6), .PRESCALE(PS), .SETTLE_TICKS(ST), .ZERO_MAX(ZM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_raw(cmp_raw),
    .bias_en(bias_en), .dac_code(dac_code), .trip_code(trip_code),
    .done(done), .limit_en(limit_en));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (thr=%0d)", rq, act, exp, thr);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    glitch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input int t, input int g);
    int  last, gap, wait_n;
    bit  gap_ok, bias_ok, seen_first;
    thr = t;
    do_reset();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    last = 0; gap = 0; gap_ok = 1; bias_ok = 1; seen_first = 0; wait_n = 0;
    while (!done && wait_n < 2000) begin
      if (!bias_en) bias_ok = 0;
      @(negedge clk);
      wait_n++;
      gap++;
      if (int'(dac_code) != last && !done) begin
        if (seen_first && g < 0 && gap != PS) gap_ok = 0;
        seen_first = 1;
        gap = 0;
        last = int'(dac_code);
        if (g > 0 && last == g) begin
          glitch = 1'b1;
          repeat (PS) @(negedge clk);
          glitch = 1'b0;
          wait_n += PS;
          gap += PS;
        end
      end
    end
    chk(done, "R8 done rises", int'(done), 1);
    chk(bias_ok, "R2 bias held during run", int'(bias_ok), 1);
    chk(!bias_en, "R2 bias off at done", int'(bias_en), 0);
    if (g < 0) chk(gap_ok, "R3 step interval", gap, PS);
    if (t <= 63) begin
      chk(int'(dac_code) == t, "R4 held code", int'(dac_code), t);
      chk(limit_en, "R4 limit enabled", int'(limit_en), 1);
      chk(int'(trip_code) == ((t <= ZM) ? 0 : t), "R6 effective code",
          int'(trip_code), (t <= ZM) ? 0 : t);
      if (g > 0) chk(int'(dac_code) == t, "R5 glitch ignored", int'(dac_code), t);
    end else begin
      chk(!limit_en, "R7 limit disabled", int'(limit_en), 0);
      chk(trip_code == 6'd0, "R7 trip zero", int'(trip_code), 0);
      chk(dac_code == 6'd63, "R7 top code", int'(dac_code), 63);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(!bias_en && !done && !limit_en, "R1 reset flags", int'({bias_en, done, limit_en}), 0);
    chk(dac_code == 0 && trip_code == 0, "R1 reset codes", int'(dac_code) + int'(trip_code), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!bias_en && !done && !limit_en, "R1 idle flags", int'({bias_en, done, limit_en}), 0);
    chk(dac_code == 0, "R1 idle code", int'(dac_code), 0);

    for (int t = 0; t <= 64; t++) run(t, -1);

    run(30, 5);
    run(11, 10);
    run(64, 40);
    run(50, 49);

    run(11, -1);
    thr = 0;
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk(done, "R8 done kept", int'(done), 1);
    chk(!bias_en, "R8 no restart bias", int'(bias_en), 0);
    chk(dac_code == 6'd11 && trip_code == 6'd11, "R8 codes held", int'(trip_code), 11);
    chk(limit_en, "R8 limit kept", int'(limit_en), 1);

    finish_run();
  end
endmodule